// File: doc/BRIEF.md
# Keyed Watchdog Timer with Reset Causes

This block is a watchdog that software must service by writing one exact byte to a key register over a simple register bus. The counter advances on ticks of a separate source clock, modelled as a tick-enable input plus a "source running" flag. If the counter reaches the end of its selected period, the block raises a reset request. A request also fires when software writes the wrong key value, touches the key register with a single-bit access, or writes the mode register a second time.

A static configuration input says whether software may stop the watchdog's oscillator. When it may, two extra behaviours apply.

- Setting the halt bit in the mode register freezes the watchdog for good. Key misuse is then ignored.
- While the source clock is reported stopped, any reset cause is held back. It is released on the first cycle the source runs again.

When the oscillator is marked as not stoppable, the watchdog always counts and every cause fires at once.

The reset request is a one-cycle pulse meant for the system reset controller. A sticky four-bit cause register records which causes fired. It survives the ordinary system reset and is cleared only by power-on reset, so that software can read it after restart.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, the key register reads 0x9A, the mode register reads 0x03 and the cause register reads 0x00. No request is raised. Register selects are: 0 = key, 1 = mode, 2 = cause. Mode bit 7 is halt and mode bits [1:0] are the period select.
- R2: A full-byte write of 0xAC to the key register clears the counter, so the next overflow comes exactly one full period later.
- R3: With period select p, the counter overflows on the 2^(CNT_W-3+p)-th counted tick after reset or service. The overflow raises a request and sets cause bit 0.
- R4: A full-byte write of any value other than 0xAC to the key register raises a request and sets cause bit 1.
- R5: A single-bit access to the key register, read or write and whatever the value, raises a request and sets cause bit 2.
- R6: A read of the key register always returns 0x9A, including after 0xAC was written.
- R7: The first mode write after reset is stored. Any later mode write raises a request, sets cause bit 3 and leaves the mode unchanged.
- R8: The request is a pulse one cycle wide, asserted in the cycle after the clock edge that captured its cause.
- R9: When the oscillator is stoppable and the source is not running, ticks are not counted and no request is issued. A pending cause is issued one cycle after the source runs again.
- R10: When the oscillator is stoppable and the halt bit is set, the counter never overflows, and a wrong key or a bit access raises no request. A second mode write still raises one.
- R11: When the oscillator is not stoppable, both the halt bit and the source-running flag are ignored.
- R12: Cause bits accumulate, are kept across the system reset and are cleared only by power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous system reset, active high |
| por | input | 1 | Synchronous power-on reset, active high; also clears causes |
| cfg_stoppable | input | 1 | Static option: software may stop the watchdog oscillator |
| src_run | input | 1 | Watchdog source clock is running |
| src_tick | input | 1 | One count of the watchdog source clock |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 key, 1 mode, 2 cause |
| bus_wdata | input | 8 | Write data |
| bus_bit | input | 1 | Access is a single-bit manipulation |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| wdt_rst_req | output | 1 | One-cycle internal reset request |

## Verification
The bench builds the block with CNT_W = 6, so the four periods are 8, 16, 32 and 64 ticks. This makes it cheap to run every period to its exact overflow tick and to check that one tick earlier stays quiet. With this small configuration, all 256 key values can be written one by one, each after a full reset. Both settings of the oscillator option are combined with the halt bit and with a stopped source to show when causes are suppressed, held back or released.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int PSEL_W = 2;
    localparam int PSEL_N = 1 << PSEL_W;

    localparam logic [7:0] KEY_READ_VAL = 8'h9A;
    localparam logic [7:0] KEY_SERVICE  = 8'hAC;

    typedef enum logic [1:0] {
        SEL_KEY   = 2'd0,
        SEL_MODE  = 2'd1,
        SEL_CAUSE = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              halt;
        logic [4:0]        spare;
        logic [PSEL_W-1:0] psel;
    } mode_t;

    localparam mode_t MODE_INIT = '{halt: 1'b0, spare: 5'd0, psel: 2'd3};

    typedef struct packed {
        logic mode_rewrite;
        logic bit_access;
        logic bad_key;
        logic overflow;
    } cause_t;

    localparam int CAUSE_W = $bits(cause_t);

    function automatic logic [7:0] cause_byte(input cause_t c);
        return {{(8 - CAUSE_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_bit,
    input  cause_t      cause,
    output mode_t       mode,
    output logic [7:0]  rdata,
    output logic        key_ok,
    output logic        key_bad,
    output logic        key_bit,
    output logic        mode_again
);

    reg_sel_e sel;
    logic     written;
    logic     key_hit;
    logic     mode_hit;

    assign sel      = reg_sel_e'(bus_addr);
    assign key_hit  = (sel == SEL_KEY);
    assign mode_hit = (sel == SEL_MODE);

    // Mode register: only the first write after reset is taken
    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= MODE_INIT;
            written <= 1'b0;
        end else if (bus_wr && mode_hit && !written) begin
            mode    <= mode_t'(bus_wdata);
            written <= 1'b1;
        end
    end

    // Key register events, decoded from the current bus cycle
    always_comb begin
        key_ok     = bus_wr && key_hit && !bus_bit && (bus_wdata == KEY_SERVICE);
        key_bad    = bus_wr && key_hit && !bus_bit && (bus_wdata != KEY_SERVICE);
        key_bit    = (bus_wr || bus_rd) && key_hit && bus_bit;
        mode_again = bus_wr && mode_hit && written;
    end

    // Readback: the key register never shows what was written
    always_comb begin
        unique case (sel)
            SEL_KEY:   rdata = KEY_READ_VAL;
            SEL_MODE:  rdata = mode;
            SEL_CAUSE: rdata = cause_byte(cause);
            default:   rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
    import kwd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              clear,
    input  logic [PSEL_W-1:0] psel,
    output logic              ovf
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_tbl [PSEL_N];

    // Terminal count for each period select: all ones, shortened
    for (genvar g = 0; g < PSEL_N; g++) begin : g_last
        assign last_tbl[g] = {CNT_W{1'b1}} >> (PSEL_N - 1 - g);
    end

    assign ovf = run && !clear && (cnt == last_tbl[psel]);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= ovf ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/kwd_cause.sv
module kwd_cause
    import kwd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   por,
    input  logic   defer,
    input  cause_t ev,
    output logic   req,
    output cause_t cause
);

    cause_t pend;
    cause_t due;

    assign due = pend | ev;

    // Causes wait in pend while the source clock is stopped
    always_ff @(posedge clk) begin
        if (rst || por) begin
            pend <= '0;
            req  <= 1'b0;
        end else if (defer) begin
            pend <= due;
            req  <= 1'b0;
        end else begin
            pend <= '0;
            req  <= |due;
        end
    end

    // Sticky record, cleared only by power-on reset
    always_ff @(posedge clk) begin
        if (por) begin
            cause <= '0;
        end else if (!rst && !defer) begin
            cause <= cause | due;
        end
    end

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import kwd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por,
    input  logic       cfg_stoppable,
    input  logic       src_run,
    input  logic       src_tick,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_bit,
    output logic [7:0] bus_rdata,
    output logic       wdt_rst_req
);

    logic   sys_rst;
    mode_t  mode;
    cause_t cause_flags;
    cause_t ev;
    logic   key_ok, key_bad, key_bit, mode_again;
    logic   halted, src_gone, run, ovf;

    assign sys_rst  = rst || por;
    assign halted   = cfg_stoppable && mode.halt;
    assign src_gone = cfg_stoppable && !src_run;
    assign run      = src_tick && !halted && !src_gone;

    kwd_regs u_regs (
        .clk        (clk),
        .rst        (sys_rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_bit    (bus_bit),
        .cause      (cause_flags),
        .mode       (mode),
        .rdata      (bus_rdata),
        .key_ok     (key_ok),
        .key_bad    (key_bad),
        .key_bit    (key_bit),
        .mode_again (mode_again)
    );

    kwd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (sys_rst),
        .run   (run),
        .clear (key_ok),
        .psel  (mode.psel),
        .ovf   (ovf)
    );

    always_comb begin
        ev.overflow     = ovf;
        ev.bad_key      = key_bad && !halted;
        ev.bit_access   = key_bit && !halted;
        ev.mode_rewrite = mode_again;
    end

    kwd_cause u_cause (
        .clk   (clk),
        .rst   (rst),
        .por   (por),
        .defer (src_gone),
        .ev    (ev),
        .req   (wdt_rst_req),
        .cause (cause_flags)
    );

endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk (
    input logic       clk,
    input logic       rst,
    input logic       por,
    input logic       cfg_stoppable,
    input logic       src_run,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_bit,
    input logic [7:0] bus_rdata,
    input logic       wdt_rst_req,
    input logic       halted,
    input logic [3:0] cause_flags
);

    AST_KEY_READBACK: assert property (@(posedge clk) disable iff (rst || por)
        bus_addr == 2'd0 |-> bus_rdata == 8'h9A); // R6

    AST_BAD_KEY_FIRES: assert property (@(posedge clk) disable iff (rst || por)
        (bus_wr && bus_addr == 2'd0 && !bus_bit && bus_wdata != 8'hAC && !cfg_stoppable)
        |=> wdt_rst_req); // R4

    AST_BIT_ACCESS_FIRES: assert property (@(posedge clk) disable iff (rst || por)
        ((bus_wr || bus_rd) && bus_addr == 2'd0 && bus_bit && !cfg_stoppable)
        |=> wdt_rst_req); // R5

    AST_QUIET_WHILE_STOPPED: assert property (@(posedge clk) disable iff (rst || por)
        (cfg_stoppable && !src_run && $past(cfg_stoppable && !src_run))
        |-> !wdt_rst_req); // R9

    AST_HALT_IGNORES_KEY: assert property (@(posedge clk) disable iff (rst || por)
        (halted && src_run && $past(src_run) && bus_wr && bus_addr == 2'd0)
        |=> !wdt_rst_req); // R10

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (por)
        !por |=> ((cause_flags & $past(cause_flags)) == $past(cause_flags))); // R12

endmodule

bind keyed_wdog keyed_wdog_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .por           (por),
    .cfg_stoppable (cfg_stoppable),
    .src_run       (src_run),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_bit       (bus_bit),
    .bus_rdata     (bus_rdata),
    .wdt_rst_req   (wdt_rst_req),
    .halted        (halted),
    .cause_flags   (cause_flags)
);

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 6;
    localparam int WATCHDOG   = 150000;

    localparam logic [1:0] A_KEY   = 2'd0;
    localparam logic [1:0] A_MODE  = 2'd1;
    localparam logic [1:0] A_CAUSE = 2'd2;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       por = 1'b0;
    logic       cfg_stoppable = 1'b0;
    logic       src_run = 1'b1;
    logic       src_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd3;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_bit = 1'b0;
    logic [7:0] bus_rdata;
    logic       wdt_rst_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    keyed_wdog #(.CNT_W(CNT_W)) u0 (
        .clk           (clk),
        .rst           (rst),
        .por           (por),
        .cfg_stoppable (cfg_stoppable),
        .src_run       (src_run),
        .src_tick      (src_tick),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_bit       (bus_bit),
        .bus_rdata     (bus_rdata),
        .wdt_rst_req   (wdt_rst_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic full_reset();
        por = 1'b1; rst = 1'b1;
        cyc(); cyc();
        por = 1'b0; rst = 1'b0;
    endtask

    task automatic sys_reset();
        rst = 1'b1;
        cyc();
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic b);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_bit = b;
        cyc();
        bus_wr = 1'b0; bus_bit = 1'b0; bus_addr = 2'd3;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0; bus_addr = 2'd3;
    endtask

    task automatic tick();
        src_tick = 1'b1;
        cyc();
        src_tick = 1'b0;
    endtask

    // Apply n ticks; return how many request pulses were seen
    task automatic ticks(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (wdt_rst_req) seen++;
        end
    endtask

    task automatic expect_cause(input logic [7:0] exp, input string tag);
        logic [7:0] v;
        rd(A_CAUSE, v);
        check(v == exp, tag, v, exp);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int seen;
        int n;

        // R1: reset state
        full_reset();
        rd(A_KEY, v);  check(v == 8'h9A, "R1 key reset", v, 8'h9A);
        rd(A_MODE, v); check(v == 8'h03, "R1 mode reset", v, 8'h03);
        expect_cause(8'h00, "R1 cause reset");
        check(wdt_rst_req == 1'b0, "R1 no request", wdt_rst_req, 0);

        // R3 / R8: overflow timing for every period select
        for (int p = 0; p < 4; p++) begin
            full_reset();
            wr(A_MODE, 8'(p), 1'b0);
            n = 1 << (CNT_W - 3 + p);
            ticks(n - 1, seen);
            check(seen == 0, "R3 early quiet", seen, 0);
            tick();
            check(wdt_rst_req == 1'b1, "R3 overflow", wdt_rst_req, 1);
            cyc();
            check(wdt_rst_req == 1'b0, "R8 pulse width", wdt_rst_req, 0);
            expect_cause(8'h01, "R3 cause bit0");
        end

        // R2: service clears the count
        full_reset();
        wr(A_MODE, 8'h00, 1'b0);
        ticks(5, seen);
        wr(A_KEY, 8'hAC, 1'b0);
        check(wdt_rst_req == 1'b0, "R2 service quiet", wdt_rst_req, 0);
        ticks(7, seen);
        check(seen == 0, "R2 full period after service", seen, 0);
        tick();
        check(wdt_rst_req == 1'b1, "R2 overflow after service", wdt_rst_req, 1);
        rd(A_KEY, v); check(v == 8'h9A, "R6 key after service", v, 8'h9A);

        // R4: sweep of every key value
        for (int k = 0; k < 256; k++) begin
            full_reset();
            wr(A_KEY, 8'(k), 1'b0);
            check(wdt_rst_req == (k != 8'hAC), "R4 key sweep", wdt_rst_req, (k != 8'hAC));
            expect_cause((k != 8'hAC) ? 8'h02 : 8'h00, "R4 key sweep cause");
            rd(A_KEY, v); check(v == 8'h9A, "R6 key readback", v, 8'h9A);
        end

        // R5: bit write and bit read of the key register
        full_reset();
        wr(A_KEY, 8'hAC, 1'b1);
        check(wdt_rst_req == 1'b1, "R5 bit write", wdt_rst_req, 1);
        expect_cause(8'h04, "R5 cause bit2");
        full_reset();
        bus_rd = 1'b1; bus_addr = A_KEY; bus_bit = 1'b1;
        cyc();
        bus_rd = 1'b0; bus_bit = 1'b0; bus_addr = 2'd3;
        check(wdt_rst_req == 1'b1, "R5 bit read", wdt_rst_req, 1);

        // R7: mode written once only
        full_reset();
        wr(A_MODE, 8'h01, 1'b0);
        check(wdt_rst_req == 1'b0, "R7 first write quiet", wdt_rst_req, 0);
        rd(A_MODE, v); check(v == 8'h01, "R7 first write stored", v, 8'h01);
        wr(A_MODE, 8'h02, 1'b0);
        check(wdt_rst_req == 1'b1, "R7 second write fires", wdt_rst_req, 1);
        rd(A_MODE, v); check(v == 8'h01, "R7 mode unchanged", v, 8'h01);
        expect_cause(8'h08, "R7 cause bit3");

        // R9: stopped source defers causes and freezes counting
        full_reset();
        cfg_stoppable = 1'b1;
        src_run = 1'b0;
        wr(A_KEY, 8'h55, 1'b0);
        check(wdt_rst_req == 1'b0, "R9 held while stopped", wdt_rst_req, 0);
        seen = 0;
        for (int i = 0; i < 3; i++) begin cyc(); if (wdt_rst_req) seen++; end
        check(seen == 0, "R9 still held", seen, 0);
        src_run = 1'b1;
        cyc();
        check(wdt_rst_req == 1'b1, "R9 released on resume", wdt_rst_req, 1);
        expect_cause(8'h02, "R9 cause after resume");
        full_reset();
        wr(A_MODE, 8'h00, 1'b0);
        src_run = 1'b0;
        ticks(20, seen);
        check(seen == 0, "R9 no count while stopped", seen, 0);
        src_run = 1'b1;
        ticks(7, seen);
        check(seen == 0, "R9 count resumes from zero", seen, 0);
        tick();
        check(wdt_rst_req == 1'b1, "R9 overflow after resume", wdt_rst_req, 1);

        // R10: halted watchdog
        full_reset();
        wr(A_MODE, 8'h80, 1'b0);
        ticks(100, seen);
        check(seen == 0, "R10 no overflow when halted", seen, 0);
        wr(A_KEY, 8'h55, 1'b0);
        check(wdt_rst_req == 1'b0, "R10 bad key ignored", wdt_rst_req, 0);
        wr(A_KEY, 8'hAC, 1'b1);
        check(wdt_rst_req == 1'b0, "R10 bit access ignored", wdt_rst_req, 0);
        expect_cause(8'h00, "R10 no cause recorded");
        wr(A_MODE, 8'h00, 1'b0);
        check(wdt_rst_req == 1'b1, "R10 mode rewrite fires", wdt_rst_req, 1);
        cfg_stoppable = 1'b0;

        // R11: not stoppable ignores halt bit and source flag
        full_reset();
        wr(A_MODE, 8'h80, 1'b0);
        ticks(7, seen);
        check(seen == 0, "R11 early quiet", seen, 0);
        tick();
        check(wdt_rst_req == 1'b1, "R11 halt ignored", wdt_rst_req, 1);
        src_run = 1'b0;
        wr(A_KEY, 8'h11, 1'b0);
        check(wdt_rst_req == 1'b1, "R11 source flag ignored", wdt_rst_req, 1);
        src_run = 1'b1;

        // R12: sticky causes
        full_reset();
        wr(A_KEY, 8'h00, 1'b0);
        wr(A_KEY, 8'h01, 1'b1);
        sys_reset();
        expect_cause(8'h06, "R12 kept across reset");
        rd(A_MODE, v); check(v == 8'h03, "R12 mode reset by rst", v, 8'h03);
        full_reset();
        expect_cause(8'h00, "R12 cleared by por");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule